// File: doc/BRIEF.md
# Write-Drain Mode Controller

This block decides, cycle by cycle, whether a memory channel's scheduler should favour reads or switch into a write-drain mode that empties the pending-write queue. It watches the current write-queue occupancy and two qualifiers: whether a read is waiting, and whether that waiting traffic is isochronous. It compares the occupancy against programmable entry and exit levels. Because the levels are separate, the mode has hysteresis. A second pair of levels takes over only when an isochronous read is waiting.

Alongside the mode decision, the block raises a priority flag for partially filled (underfill) writes once the queue grows past its own programmable level. It also runs an 8-bit priority timeout counter. Software programs only the top three bits of that counter's terminal value, and the low five bits always count through their full range. All levels and the timeout setting arrive as plain input ports, and every output is a register.

Top module: `wm_drain_ctrl`

## Requirements
- R1: `write_major` rises one clock after a cycle in which it is low and `wq_count` is strictly greater than the active entry level. When `wq_count` equals or is below that level, the flag stays low.
- R2: `write_major` falls one clock after a cycle in which it is high and `wq_count` is strictly below the active exit level. When `wq_count` equals or is above that level, the flag stays high.
- R3: The active entry/exit pair is (`thr_iso_entry`, `thr_iso_exit`) only in cycles where `rd_pending` and `rd_isoc` are both 1. In all other cycles it is (`thr_wm_entry`, `thr_wm_exit`).
- R4: A synchronous active-high `rst` clears `write_major`, `partial_raise`, `timeout` and the priority counter. All outputs are registered and react one clock after their inputs.
- R5: `partial_raise` is 1 one clock after a cycle in which `thr_partial` is not 31 and `wq_count` > `thr_partial`. It is 0 otherwise, so a setting of 31 disables it.
- R6: The priority counter advances only in cycles where `rd_pending` is 1 or `wq_count` is nonzero. In idle cycles it holds, and `timeout` stays 0.
- R7: `timeout` is a one-cycle pulse. It fires on the advancing cycle in which the counter equals {`tmo_hi`, 5'b11111}, and in that same cycle the counter reloads to 0. When the counter advances every cycle from reset, the first pulse appears 32*(`tmo_hi`+1) clocks after reset release, and later pulses follow at the same period.
- R8: An entry level of 31 never starts write-drain mode, because a 5-bit `wq_count` cannot exceed 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wq_count | input | 5 | Writes currently held in the write queue |
| rd_pending | input | 1 | A read is waiting |
| rd_isoc | input | 1 | Waiting traffic is isochronous |
| thr_wm_entry | input | 5 | Normal entry level |
| thr_wm_exit | input | 5 | Normal exit level |
| thr_iso_entry | input | 5 | Isochronous entry level |
| thr_iso_exit | input | 5 | Isochronous exit level |
| thr_partial | input | 5 | Underfill priority level (31 disables) |
| tmo_hi | input | 3 | Upper bits of the timeout terminal value |
| write_major | output | 1 | Write-drain mode active |
| partial_raise | output | 1 | Raise underfill write priority |
| timeout | output | 1 | Priority timeout pulse |

## Verification
The hardest situation to reach is the mode being held while the occupancy sits exactly on a level or between the two levels, with the qualifiers switching which pair applies. The stimulus reaches it with a walked vector table that first drives the queue count above the entry level. The table then steps the count down through the band to the exit level and one below it. Next it repeats the sweep with `rd_pending` and `rd_isoc` raised alone and together, so that only the pair selection changes. Directed runs then program every level to 31 at a full queue. They also time the counter at two `tmo_hi` settings.

// File: rtl/wm_drain_pkg.sv
package wm_drain_pkg;

  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_DRAIN = 1'b1
  } drain_mode_e;

  localparam int unsigned DEF_CNT_W    = 5;
  localparam int unsigned DEF_TMO_W    = 8;
  localparam int unsigned DEF_TMO_HI_W = 3;

endpackage

// File: rtl/wm_pair_select.sv
module wm_pair_select #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             rd_pending,
  input  logic             rd_isoc,
  input  logic [CNT_W-1:0] thr_wm_entry,
  input  logic [CNT_W-1:0] thr_wm_exit,
  input  logic [CNT_W-1:0] thr_iso_entry,
  input  logic [CNT_W-1:0] thr_iso_exit,
  output logic [CNT_W-1:0] entry_lvl,
  output logic [CNT_W-1:0] exit_lvl
);

  logic use_iso;

  always_comb begin
    use_iso = rd_pending & rd_isoc;
    if (use_iso) begin
      entry_lvl = thr_iso_entry;
      exit_lvl  = thr_iso_exit;
    end else begin
      entry_lvl = thr_wm_entry;
      exit_lvl  = thr_wm_exit;
    end
  end

endmodule

// File: rtl/wm_mode_fsm.sv
module wm_mode_fsm
  import wm_drain_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wq_count,
  input  logic [CNT_W-1:0] entry_lvl,
  input  logic [CNT_W-1:0] exit_lvl,
  output logic             drain_on
);

  drain_mode_e mode_q, mode_d;
  logic        go_drain, go_read;

  always_comb begin
    go_drain = (wq_count > entry_lvl);
    go_read  = (wq_count < exit_lvl);
    mode_d   = mode_q;
    unique case (mode_q)
      MODE_READ:  if (go_drain) mode_d = MODE_DRAIN;
      MODE_DRAIN: if (go_read)  mode_d = MODE_READ;
      default:    mode_d = MODE_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_READ;
    else     mode_q <= mode_d;
  end

  assign drain_on = (mode_q == MODE_DRAIN);

endmodule

// File: rtl/wm_underfill_raise.sv
module wm_underfill_raise #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wq_count,
  input  logic [CNT_W-1:0] thr_partial,
  output logic             raise_q
);

  localparam logic [CNT_W-1:0] OFF_CODE = {CNT_W{1'b1}};

  logic enabled, crossed;

  always_comb begin
    enabled = (thr_partial != OFF_CODE);
    crossed = (wq_count > thr_partial);
  end

  always_ff @(posedge clk) begin
    if (rst) raise_q <= 1'b0;
    else     raise_q <= enabled & crossed;
  end

endmodule

// File: rtl/wm_prio_timer.sv
module wm_prio_timer #(
  parameter int unsigned TMO_W    = 8,
  parameter int unsigned TMO_HI_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  logic [TMO_HI_W-1:0] tmo_hi,
  output logic                expire_q
);

  localparam int unsigned LO_W = TMO_W - TMO_HI_W;

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] terminal;
  logic             at_end;

  always_comb begin
    terminal = {tmo_hi, {LO_W{1'b1}}};
    at_end   = (cnt_q == terminal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (advance) begin
      if (at_end) begin
        cnt_q    <= '0;
        expire_q <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        expire_q <= 1'b0;
      end
    end else begin
      expire_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wm_drain_ctrl.sv
module wm_drain_ctrl
  import wm_drain_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned TMO_W    = DEF_TMO_W,
  parameter int unsigned TMO_HI_W = DEF_TMO_HI_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    wq_count,
  input  logic                rd_pending,
  input  logic                rd_isoc,
  input  logic [CNT_W-1:0]    thr_wm_entry,
  input  logic [CNT_W-1:0]    thr_wm_exit,
  input  logic [CNT_W-1:0]    thr_iso_entry,
  input  logic [CNT_W-1:0]    thr_iso_exit,
  input  logic [CNT_W-1:0]    thr_partial,
  input  logic [TMO_HI_W-1:0] tmo_hi,
  output logic                write_major,
  output logic                partial_raise,
  output logic                timeout
);

  logic [CNT_W-1:0] entry_lvl, exit_lvl;
  logic             busy;

  assign busy = rd_pending | (|wq_count);

  wm_pair_select #(.CNT_W(CNT_W)) u_sel (
    .rd_pending    (rd_pending),
    .rd_isoc       (rd_isoc),
    .thr_wm_entry  (thr_wm_entry),
    .thr_wm_exit   (thr_wm_exit),
    .thr_iso_entry (thr_iso_entry),
    .thr_iso_exit  (thr_iso_exit),
    .entry_lvl     (entry_lvl),
    .exit_lvl      (exit_lvl)
  );

  wm_mode_fsm #(.CNT_W(CNT_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .wq_count  (wq_count),
    .entry_lvl (entry_lvl),
    .exit_lvl  (exit_lvl),
    .drain_on  (write_major)
  );

  wm_underfill_raise #(.CNT_W(CNT_W)) u_raise (
    .clk         (clk),
    .rst         (rst),
    .wq_count    (wq_count),
    .thr_partial (thr_partial),
    .raise_q     (partial_raise)
  );

  wm_prio_timer #(.TMO_W(TMO_W), .TMO_HI_W(TMO_HI_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .advance  (busy),
    .tmo_hi   (tmo_hi),
    .expire_q (timeout)
  );

endmodule

// File: rtl/wm_drain_ctrl_chk.sv
module wm_drain_ctrl_chk #(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned TMO_HI_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [CNT_W-1:0]    wq_count,
  input logic                rd_pending,
  input logic                rd_isoc,
  input logic [CNT_W-1:0]    thr_wm_entry,
  input logic [CNT_W-1:0]    thr_wm_exit,
  input logic [CNT_W-1:0]    thr_iso_entry,
  input logic [CNT_W-1:0]    thr_iso_exit,
  input logic [CNT_W-1:0]    thr_partial,
  input logic [TMO_HI_W-1:0] tmo_hi,
  input logic                write_major,
  input logic                partial_raise,
  input logic                timeout
);

  logic [CNT_W-1:0] ent_c, ext_c;
  assign ent_c = (rd_pending && rd_isoc) ? thr_iso_entry : thr_wm_entry;
  assign ext_c = (rd_pending && rd_isoc) ? thr_iso_exit  : thr_wm_exit;

  // R1, R3
  a_r1_enter: assert property (@(posedge clk) disable iff (rst)
    (!write_major && wq_count > ent_c) |=> write_major);
  a_r1_stay_read: assert property (@(posedge clk) disable iff (rst)
    (!write_major && wq_count <= ent_c) |=> !write_major);
  // R2, R3
  a_r2_leave: assert property (@(posedge clk) disable iff (rst)
    (write_major && wq_count < ext_c) |=> !write_major);
  a_r2_stay_drain: assert property (@(posedge clk) disable iff (rst)
    (write_major && wq_count >= ext_c) |=> write_major);
  // R4
  a_r4_reset_clears: assert property (@(posedge clk)
    rst |=> (!write_major && !partial_raise && !timeout));
  // R5
  a_r5_raise_on: assert property (@(posedge clk) disable iff (rst)
    (thr_partial != {CNT_W{1'b1}} && wq_count > thr_partial) |=> partial_raise);
  a_r5_raise_off: assert property (@(posedge clk) disable iff (rst)
    (thr_partial == {CNT_W{1'b1}} || wq_count <= thr_partial) |=> !partial_raise);
  // R6
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rd_pending && wq_count == '0) |=> !timeout);
  // R7
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
  // R8
  a_r8_top_level_inert: assert property (@(posedge clk) disable iff (rst)
    (!write_major && ent_c == {CNT_W{1'b1}}) |=> !write_major);

endmodule

bind wm_drain_ctrl wm_drain_ctrl_chk #(.CNT_W(CNT_W), .TMO_HI_W(TMO_HI_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wq_count      (wq_count),
  .rd_pending    (rd_pending),
  .rd_isoc       (rd_isoc),
  .thr_wm_entry  (thr_wm_entry),
  .thr_wm_exit   (thr_wm_exit),
  .thr_iso_entry (thr_iso_entry),
  .thr_iso_exit  (thr_iso_exit),
  .thr_partial   (thr_partial),
  .tmo_hi        (tmo_hi),
  .write_major   (write_major),
  .partial_raise (partial_raise),
  .timeout       (timeout)
);

// File: tb/wm_drain_ctrl_tb_top.sv
`timescale 1ns/1ps
module wm_drain_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] wq_count;
  logic       rd_pending, rd_isoc;
  logic [4:0] thr_wm_entry, thr_wm_exit, thr_iso_entry, thr_iso_exit, thr_partial;
  logic [2:0] tmo_hi;
  logic       write_major, partial_raise, timeout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  wm_drain_ctrl dut_i (
    .clk(clk), .rst(rst), .wq_count(wq_count), .rd_pending(rd_pending),
    .rd_isoc(rd_isoc), .thr_wm_entry(thr_wm_entry), .thr_wm_exit(thr_wm_exit),
    .thr_iso_entry(thr_iso_entry), .thr_iso_exit(thr_iso_exit),
    .thr_partial(thr_partial), .tmo_hi(tmo_hi), .write_major(write_major),
    .partial_raise(partial_raise), .timeout(timeout)
  );

  // {count[4:0], rd_pending, rd_isoc, expected write_major}
  // normal pair 22/10, isochronous pair 12/5
  localparam logic [7:0] VEC [15] = '{
    {5'd20, 1'b0, 1'b0, 1'b0},
    {5'd22, 1'b0, 1'b0, 1'b0},
    {5'd23, 1'b0, 1'b0, 1'b1},
    {5'd15, 1'b0, 1'b0, 1'b1},
    {5'd10, 1'b0, 1'b0, 1'b1},
    {5'd9,  1'b0, 1'b0, 1'b0},
    {5'd13, 1'b1, 1'b0, 1'b0},
    {5'd13, 1'b0, 1'b1, 1'b0},
    {5'd13, 1'b1, 1'b1, 1'b1},
    {5'd8,  1'b1, 1'b1, 1'b1},
    {5'd8,  1'b0, 1'b0, 1'b0},
    {5'd13, 1'b1, 1'b1, 1'b1},
    {5'd4,  1'b1, 1'b1, 1'b0},
    {5'd31, 1'b0, 1'b0, 1'b1},
    {5'd0,  1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic [4:0] c, input logic rp, input logic ri);
    wq_count = c; rd_pending = rp; rd_isoc = ri;
    @(negedge clk);
  endtask

  task automatic measure_period(input logic [2:0] hi, input int exp, input string req);
    int n;
    tmo_hi = hi; wq_count = 5'd0; rd_pending = 1'b0; rd_isoc = 1'b0;
    do_reset();
    rd_pending = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!timeout && n < 400);
      check_int(req, n, exp);
      @(negedge clk);
      check({req, " pulse width"}, timeout, 1'b0);
      n = 1;
      // account for the cycle just consumed in the next period
      while (!timeout && n < 400) begin
        @(negedge clk);
        n++;
      end
      check_int({req, " repeat"}, n, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wq_count = '0; rd_pending = 1'b0; rd_isoc = 1'b0;
    thr_wm_entry = 5'd22; thr_wm_exit = 5'd10;
    thr_iso_entry = 5'd12; thr_iso_exit = 5'd5;
    thr_partial = 5'd20; tmo_hi = 3'd7;
    repeat (2) @(negedge clk);
    // R4: outputs cleared while reset held
    check("R4 reset write_major", write_major, 1'b0);
    check("R4 reset partial_raise", partial_raise, 1'b0);
    check("R4 reset timeout", timeout, 1'b0);
    rst = 1'b0;

    // R1, R2, R3, R5: table walk
    for (int i = 0; i < 15; i++) begin
      step(VEC[i][7:3], VEC[i][2], VEC[i][1]);
      check($sformatf("R1/R2/R3 vec %0d", i), write_major, VEC[i][0]);
      check($sformatf("R5 vec %0d", i), partial_raise,
            (thr_partial != 5'd31) && (VEC[i][7:3] > thr_partial));
    end

    // R8: entry level 31 with a full queue never enters
    thr_wm_entry = 5'd31; thr_iso_entry = 5'd31;
    step(5'd31, 1'b0, 1'b0);
    check("R8 normal entry 31", write_major, 1'b0);
    step(5'd31, 1'b1, 1'b1);
    check("R8 iso entry 31", write_major, 1'b0);

    // R5: partial level 31 disables even at full queue
    thr_partial = 5'd31;
    step(5'd31, 1'b0, 1'b0);
    check("R5 partial disabled", partial_raise, 1'b0);
    thr_partial = 5'd30;
    step(5'd31, 1'b0, 1'b0);
    check("R5 partial 30 crossed", partial_raise, 1'b1);

    // R2: exit level 31 leaves at 30, holds at 31
    thr_wm_entry = 5'd22; thr_wm_exit = 5'd31;
    step(5'd23, 1'b0, 1'b0);
    check("R1 enter before exit test", write_major, 1'b1);
    step(5'd31, 1'b0, 1'b0);
    check("R2 hold at exit 31", write_major, 1'b1);
    step(5'd30, 1'b0, 1'b0);
    check("R2 leave below exit 31", write_major, 1'b0);

    // R4: reset from drain mode
    thr_wm_exit = 5'd10;
    step(5'd25, 1'b0, 1'b0);
    check("R1 enter before reset", write_major, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R4 reset from drain", write_major, 1'b0);
    check("R4 reset clears raise", partial_raise, 1'b0);
    rst = 1'b0;

    // R6: idle inputs never time out
    tmo_hi = 3'd0;
    do_reset();
    wq_count = 5'd0; rd_pending = 1'b0; rd_isoc = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (timeout) seen++;
      end
      check_int("R6 idle no timeout", seen, 0);
    end

    // R7: timeout period for two terminal settings
    measure_period(3'd0, 32, "R7 tmo_hi=0");
    measure_period(3'd2, 96, "R7 tmo_hi=2");

    // R6: queue occupancy alone also advances the counter
    tmo_hi = 3'd0; rd_pending = 1'b0; wq_count = 5'd0;
    do_reset();
    wq_count = 5'd1;
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!timeout && n < 400);
      check_int("R6 queue advances counter", n, 32);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule